// File: doc/BRIEF.md
# Video DAC Output Formatter

This block sits between the tail of a video encoder and the digital-to-analog converters. On every pixel clock it takes one luma sample, one chroma sample and one red, green and blue sample. It produces the codes that feed six converters: luma, chroma, a composite signal and the three colour channels. The composite code is the luma sample plus the chroma sample, where chroma is offset-binary about a mid-scale of 512. The sum is then scaled down to 15/16 so that the composite converter uses its full range without clipping typical signals, and saturated into the 10-bit code range.

Every path is padded to the same fixed pipeline latency, so all six converters show the same pixel on the same clock. A small output-control state machine sits in the last register. It has three states. ST_HIZ is the reset state: the outputs are not driven. ST_RUN passes pipeline data with the outputs enabled. ST_FORCE drives every code to zero with the outputs enabled.

The transitions are taken on every clock. Any state goes to ST_HIZ while `hiz_en` is high. Any state goes to ST_FORCE while `force_min` is high and `hiz_en` is low. Any state goes to ST_RUN when both controls are low. The output register is loaded from the next state, so a control change shows on the outputs one clock after it is sampled. The data pipeline never stops, whatever the state.

Top module: `vdac_out_fmt`

## Requirements
- R1: While `rst_n` is low, all data outputs are 0 and `dac_oe` is 0. The control state is ST_HIZ.
- R2: Luma, chroma, red, green and blue pass through unchanged with a latency of LATENCY (82) clocks. A sample captured on rising edge n appears on the outputs just after edge n+81, and not earlier.
- R3: The composite code is floor((luma + chroma − 512) × 15 / 16) when that value lies between 0 and 1023.
- R4: The composite code saturates. A negative scaled value gives 0, and a scaled value above 1023 gives 1023. A sum of 1092 gives exactly 1023, and a sum of 1093 is clamped to 1023.
- R5: The composite output has the same 82-clock latency as the other five outputs.
- R6: When `force_min` is high and `hiz_en` is low on a rising edge, every data output is 0 and `dac_oe` is 1 just after that edge.
- R7: When `hiz_en` is high on a rising edge, `dac_oe` is 0 just after that edge. The data outputs keep showing pipeline data, with their normal latency.
- R8: `hiz_en` has priority over `force_min`. With both high, `dac_oe` is 0 and the data outputs carry pipeline data rather than zero.
- R9: With both controls low on a rising edge, `dac_oe` is 1 and the outputs carry pipeline data just after that edge. This includes the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| force_min | input | 1 | Software control: drive every output code to zero |
| hiz_en | input | 1 | Software control: release the converter buffers (power save) |
| luma_in | input | 10 | Luma sample |
| chroma_in | input | 10 | Chroma sample, offset-binary about 512 |
| red_in | input | 9 | Red sample |
| green_in | input | 9 | Green sample |
| blue_in | input | 9 | Blue sample |
| luma_out | output | 10 | Luma converter code |
| chroma_out | output | 10 | Chroma converter code |
| cvbs_out | output | 10 | Composite converter code |
| red_out | output | 9 | Red converter code |
| green_out | output | 9 | Green converter code |
| blue_out | output | 9 | Blue converter code |
| dac_oe | output | 1 | Output-buffer enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports is the tri-state state while fresh data is still moving through the 82-stage pipeline. To reach it, the bench raises `hiz_en` on the same clock that it presents a new pixel. It then checks that the old value is still present one clock before the latency expires and that the new value appears exactly on time with `dac_oe` low. The composite clamp boundary is reached with sums chosen to land exactly on 1023 and one step beyond it, and a sum of −1 exercises the negative clamp. The impulse vector at the head of the table shows that nothing reaches any output before the 82nd edge.

// File: rtl/vdac_fmt_pkg.sv
package vdac_fmt_pkg;

    // Output-control states of the converter interface.
    typedef enum logic [1:0] {
        ST_HIZ   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FORCE = 2'd2
    } vdac_state_e;

endpackage

// File: rtl/vdac_cvbs_mix.sv
// Two-stage composite former: offset-removed sum, then scale and clamp.
module vdac_cvbs_mix #(
    parameter int DW        = 10,
    parameter int MID       = 512,
    parameter int SCALE_NUM = 15,
    parameter int SCALE_SH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] luma_i,
    input  logic [DW-1:0] chroma_i,
    output logic [DW-1:0] cvbs_o
);
    localparam int SW   = DW + 3;
    localparam int PW   = SW + SCALE_SH + 1;
    localparam int MAXC = (1 << DW) - 1;

    logic [SW-1:0]        sum_raw;
    logic signed [SW-1:0] sum_q;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic [DW-1:0]        sat_d;

    assign sum_raw = SW'(luma_i) + SW'(chroma_i) - SW'(MID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= $signed(sum_raw);
        end
    end

    always_comb begin
        prod   = $signed({{(PW-SW){sum_q[SW-1]}}, sum_q}) * $signed(PW'(SCALE_NUM));
        scaled = prod >>> SCALE_SH;
        if (scaled[PW-1]) begin
            sat_d = '0;
        end else if (scaled[PW-2:0] > (PW-1)'(MAXC)) begin
            sat_d = DW'(MAXC);
        end else begin
            sat_d = scaled[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cvbs_o <= '0;
        end else begin
            cvbs_o <= sat_d;
        end
    end

endmodule

// File: rtl/vdac_delay_line.sv
// Fixed-depth shift register used to pad a path to the common latency.
module vdac_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_shift
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        stg[i] <= '0;
                    end
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/vdac_out_ctrl.sv
// Output-control state machine and the final output register.
module vdac_out_ctrl
    import vdac_fmt_pkg::*;
#(
    parameter int YW = 10,
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_min,
    input  logic          hiz_en,
    input  logic [YW-1:0] y_i,
    input  logic [YW-1:0] c_i,
    input  logic [YW-1:0] cv_i,
    input  logic [RW-1:0] r_i,
    input  logic [RW-1:0] g_i,
    input  logic [RW-1:0] b_i,
    output logic [YW-1:0] y_o,
    output logic [YW-1:0] c_o,
    output logic [YW-1:0] cv_o,
    output logic [RW-1:0] r_o,
    output logic [RW-1:0] g_o,
    output logic [RW-1:0] b_o,
    output logic          oe_o
);
    vdac_state_e state_q, state_d;

    // Next-state logic: tri-state wins over force-to-minimum.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HIZ: begin
                if (hiz_en)         state_d = ST_HIZ;
                else if (force_min) state_d = ST_FORCE;
                else                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (hiz_en)         state_d = ST_HIZ;
                else if (force_min) state_d = ST_FORCE;
                else                state_d = ST_RUN;
            end
            ST_FORCE: begin
                if (hiz_en)         state_d = ST_HIZ;
                else if (force_min) state_d = ST_FORCE;
                else                state_d = ST_RUN;
            end
            default:                state_d = ST_HIZ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HIZ;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register follows the next state so a control acts in one clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_o  <= '0;
            c_o  <= '0;
            cv_o <= '0;
            r_o  <= '0;
            g_o  <= '0;
            b_o  <= '0;
            oe_o <= 1'b0;
        end else begin
            unique case (state_d)
                ST_FORCE: begin
                    y_o  <= '0;
                    c_o  <= '0;
                    cv_o <= '0;
                    r_o  <= '0;
                    g_o  <= '0;
                    b_o  <= '0;
                    oe_o <= 1'b1;
                end
                ST_RUN: begin
                    y_o  <= y_i;
                    c_o  <= c_i;
                    cv_o <= cv_i;
                    r_o  <= r_i;
                    g_o  <= g_i;
                    b_o  <= b_i;
                    oe_o <= 1'b1;
                end
                default: begin
                    y_o  <= y_i;
                    c_o  <= c_i;
                    cv_o <= cv_i;
                    r_o  <= r_i;
                    g_o  <= g_i;
                    b_o  <= b_i;
                    oe_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vdac_out_fmt.sv
// Top: input register, composite former, latency padding, output control.
module vdac_out_fmt #(
    parameter int Y_W         = 10,
    parameter int RGB_W       = 9,
    parameter int LATENCY     = 82,
    parameter int CHROMA_MID  = 512,
    parameter int SCALE_NUM   = 15,
    parameter int SCALE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_min,
    input  logic             hiz_en,
    input  logic [Y_W-1:0]   luma_in,
    input  logic [Y_W-1:0]   chroma_in,
    input  logic [RGB_W-1:0] red_in,
    input  logic [RGB_W-1:0] green_in,
    input  logic [RGB_W-1:0] blue_in,
    output logic [Y_W-1:0]   luma_out,
    output logic [Y_W-1:0]   chroma_out,
    output logic [Y_W-1:0]   cvbs_out,
    output logic [RGB_W-1:0] red_out,
    output logic [RGB_W-1:0] green_out,
    output logic [RGB_W-1:0] blue_out,
    output logic             dac_oe
);
    localparam int IN_STAGES  = 1;
    localparam int MIX_STAGES = 2;
    localparam int OUT_STAGES = 1;
    localparam int PAD_CV     = LATENCY - IN_STAGES - MIX_STAGES - OUT_STAGES;
    localparam int PAD_YC     = PAD_CV + MIX_STAGES;
    localparam int BW         = 2 * Y_W + 3 * RGB_W;

    logic [Y_W-1:0]   luma_q, chroma_q;
    logic [RGB_W-1:0] red_q, green_q, blue_q;
    logic [Y_W-1:0]   cvbs_mix, cvbs_al;
    logic [BW-1:0]    bundle_al;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            luma_q   <= '0;
            chroma_q <= '0;
            red_q    <= '0;
            green_q  <= '0;
            blue_q   <= '0;
        end else begin
            luma_q   <= luma_in;
            chroma_q <= chroma_in;
            red_q    <= red_in;
            green_q  <= green_in;
            blue_q   <= blue_in;
        end
    end

    vdac_cvbs_mix #(
        .DW(Y_W), .MID(CHROMA_MID), .SCALE_NUM(SCALE_NUM), .SCALE_SH(SCALE_SHIFT)
    ) u_mix (
        .clk(clk), .rst_n(rst_n),
        .luma_i(luma_q), .chroma_i(chroma_q), .cvbs_o(cvbs_mix)
    );

    vdac_delay_line #(.W(Y_W), .DEPTH(PAD_CV)) u_pad_cv (
        .clk(clk), .rst_n(rst_n), .d(cvbs_mix), .q(cvbs_al)
    );

    vdac_delay_line #(.W(BW), .DEPTH(PAD_YC)) u_pad_yc (
        .clk(clk), .rst_n(rst_n),
        .d({luma_q, chroma_q, red_q, green_q, blue_q}), .q(bundle_al)
    );

    vdac_out_ctrl #(.YW(Y_W), .RW(RGB_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .force_min(force_min), .hiz_en(hiz_en),
        .y_i(bundle_al[BW-1 -: Y_W]),
        .c_i(bundle_al[BW-Y_W-1 -: Y_W]),
        .cv_i(cvbs_al),
        .r_i(bundle_al[3*RGB_W-1 -: RGB_W]),
        .g_i(bundle_al[2*RGB_W-1 -: RGB_W]),
        .b_i(bundle_al[RGB_W-1 -: RGB_W]),
        .y_o(luma_out), .c_o(chroma_out), .cv_o(cvbs_out),
        .r_o(red_out), .g_o(green_out), .b_o(blue_out),
        .oe_o(dac_oe)
    );

endmodule

// File: rtl/vdac_out_fmt_chk.sv
module vdac_out_fmt_chk #(
    parameter int Y_W   = 10,
    parameter int RGB_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_min,
    input logic             hiz_en,
    input logic [Y_W-1:0]   luma_out,
    input logic [Y_W-1:0]   chroma_out,
    input logic [Y_W-1:0]   cvbs_out,
    input logic [RGB_W-1:0] red_out,
    input logic [RGB_W-1:0] green_out,
    input logic [RGB_W-1:0] blue_out,
    input logic             dac_oe
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!dac_oe && luma_out == '0 && chroma_out == '0 && cvbs_out == '0 &&
                    red_out == '0 && green_out == '0 && blue_out == '0));

    a_r6_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && !hiz_en) |=> (dac_oe && luma_out == '0 && chroma_out == '0 &&
            cvbs_out == '0 && red_out == '0 && green_out == '0 && blue_out == '0));

    a_r7_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_en |=> !dac_oe);

    a_r8_hiz_over_force: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_en && force_min) |=> !dac_oe);

    a_r9_run_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!hiz_en && !force_min) |=> dac_oe);

endmodule

bind vdac_out_fmt vdac_out_fmt_chk #(.Y_W(Y_W), .RGB_W(RGB_W)) u_chk (.*);

// File: tb/tb_vdac_out_fmt.sv
`timescale 1ns/1ps
module tb_vdac_out_fmt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       force_min = 1'b0;
    logic       hiz_en = 1'b0;
    logic [9:0] luma_in = '0, chroma_in = '0;
    logic [8:0] red_in = '0, green_in = '0, blue_in = '0;
    logic [9:0] luma_out, chroma_out, cvbs_out;
    logic [8:0] red_out, green_out, blue_out;
    logic       dac_oe;

    always #5 clk = ~clk;

    vdac_out_fmt dut (
        .clk(clk), .rst_n(rst_n), .force_min(force_min), .hiz_en(hiz_en),
        .luma_in(luma_in), .chroma_in(chroma_in),
        .red_in(red_in), .green_in(green_in), .blue_in(blue_in),
        .luma_out(luma_out), .chroma_out(chroma_out), .cvbs_out(cvbs_out),
        .red_out(red_out), .green_out(green_out), .blue_out(blue_out),
        .dac_oe(dac_oe)
    );

    // Fields: luma[46:37] chroma[36:27] red[26:18] green[17:9] blue[8:0]
    localparam int NV = 16;
    localparam logic [46:0] VEC [NV] = '{
        {10'd1023, 10'd1023, 9'd511, 9'd0,   9'd0},
        {10'd0,    10'd0,    9'd0,   9'd511, 9'd0},
        {10'd0,    10'd512,  9'd0,   9'd0,   9'd511},
        {10'd512,  10'd512,  9'd100, 9'd200, 9'd300},
        {10'd1023, 10'd512,  9'd1,   9'd2,   9'd3},
        {10'd1023, 10'd581,  9'd17,  9'd34,  9'd51},
        {10'd1023, 10'd582,  9'd255, 9'd256, 9'd257},
        {10'd513,  10'd1,    9'd5,   9'd6,   9'd7},
        {10'd511,  10'd0,    9'd8,   9'd9,   9'd10},
        {10'd300,  10'd700,  9'd400, 9'd401, 9'd402},
        {10'd800,  10'd100,  9'd11,  9'd22,  9'd33},
        {10'd64,   10'd900,  9'd44,  9'd55,  9'd66},
        {10'd1000, 10'd50,   9'd77,  9'd88,  9'd99},
        {10'd256,  10'd256,  9'd123, 9'd234, 9'd345},
        {10'd700,  10'd400,  9'd480, 9'd490, 9'd500},
        {10'd5,    10'd1020, 9'd12,  9'd13,  9'd14}
    };
    localparam logic [46:0] FILL = {10'd700, 10'd600, 9'd300, 9'd301, 9'd302};
    localparam logic [46:0] NEWV = {10'd900, 10'd350, 9'd111, 9'd222, 9'd333};
    localparam logic [46:0] ZERO = '0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    function automatic int exp_cvbs(int l, int c);
        int s;
        s = (l + c - 512) * 15;
        if (s < 0) return 0;
        s = s / 16;
        if (s > 1023) return 1023;
        return s;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs against a vector; zero_codes models ST_FORCE.
    task automatic chk_all(string req, logic [46:0] v, bit oe_exp, bit zero_codes);
        logic [46:0] e;
        e = zero_codes ? ZERO : v;
        chk(req, "luma",   int'(luma_out),   int'(e[46:37]));
        chk(req, "chroma", int'(chroma_out), int'(e[36:27]));
        chk(req, "cvbs",   int'(cvbs_out),
            zero_codes ? 0 : exp_cvbs(int'(v[46:37]), int'(v[36:27])));
        chk(req, "red",    int'(red_out),    int'(e[26:18]));
        chk(req, "green",  int'(green_out),  int'(e[17:9]));
        chk(req, "blue",   int'(blue_out),   int'(e[8:0]));
        chk(req, "oe",     int'(dac_oe),     int'(oe_exp));
    endtask

    task automatic drive(logic [46:0] v);
        luma_in   = v[46:37];
        chroma_in = v[36:27];
        red_in    = v[26:18];
        green_in  = v[17:9];
        blue_in   = v[8:0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 reset", ZERO, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R9 run after reset", ZERO, 1'b1, 1'b0);

        // Table walk: vector k driven at negedge N0+k, seen at N0+k+82.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k]);
        end
        @(negedge clk);
        drive(FILL);
        repeat (65) @(negedge clk);
        chk_all("R2 R5 nothing before latency", ZERO, 1'b1, 1'b0);
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            chk_all("R2 R3 R4 R5 table", VEC[k], 1'b1, 1'b0);
        end

        repeat (3) @(negedge clk);
        chk_all("R2 steady", FILL, 1'b1, 1'b0);

        force_min = 1'b1;
        @(negedge clk);
        chk_all("R6 force", FILL, 1'b1, 1'b1);
        hiz_en = 1'b1;
        @(negedge clk);
        chk_all("R8 hiz over force", FILL, 1'b0, 1'b0);
        force_min = 1'b0;
        @(negedge clk);
        chk_all("R7 hiz", FILL, 1'b0, 1'b0);
        hiz_en = 1'b0;
        @(negedge clk);
        chk_all("R9 release", FILL, 1'b1, 1'b0);

        // New data enters while the outputs are released.
        hiz_en = 1'b1;
        drive(NEWV);
        repeat (81) @(negedge clk);
        chk_all("R7 pipeline running, old data", FILL, 1'b0, 1'b0);
        @(negedge clk);
        chk_all("R7 pipeline running, new data", NEWV, 1'b0, 1'b0);
        hiz_en = 1'b0;
        @(negedge clk);
        chk_all("R9 enable again", NEWV, 1'b1, 1'b0);
        force_min = 1'b1;
        @(negedge clk);
        chk_all("R6 force again", NEWV, 1'b1, 1'b1);
        force_min = 1'b0;
        @(negedge clk);
        chk_all("R9 leave force", NEWV, 1'b1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule